// File: doc/BRIEF.md
# Flash Bulk-Erase Sequencer with Blank Verify

This block runs a whole-array erase of a flash memory with no software involved. A start strobe launches it. It first checks that the programming supply reports present. It then sets erase mode and opens the latches together, and issues one dummy write to arm the array. After that it applies long high-voltage pulses. Each pulse is followed by a quiet settling window.

After every pulse the block reads the user area one 16-bit word at a time, starting at word 0. A word counts as blank when every bit is one. The first word that is not blank ends the scan. The protected boot region sits above the user area and is never read.

Once a scan passes, the block replays as many pulses as it took to reach a blank array, as erase margin. A final scan then confirms the result. The block ends by raising `done` or `error`, and that flag holds until the next start.

Top module: `flash_erase_seq`

## Requirements
- R1: During and after reset, with no start, every output is low and `rdAddr` is zero.
- R2: If `vfpOk` is low when `start` is sampled in an idle state, `error` rises on the next cycle. No write strobe and no high-voltage pulse are issued.
- R3: On an accepted start, `eraseSel` and `latchEn` rise in the same cycle. A single-cycle `wrStrobe` is issued while both are high, before the first high-voltage pulse.
- R4: Each `hvEn` pulse lasts exactly PULSE_CYCLES cycles. It is followed by exactly SETTLE_CYCLES cycles with `hvEn` low before the next read or pulse.
- R5: A blank scan issues `rdStrobe` with `rdAddr` counting 0, 1, 2 … upward. `rdData` is taken one cycle after each strobe. A word is blank only when it equals 0xFFFF.
- R6: A scan stops at the first word that is not blank. No higher address is read in that scan.
- R7: Scans read only word addresses 0 to CHECK_WORDS−1. Words at or above CHECK_WORDS (the boot region) are never read and do not affect the outcome.
- R8: If the first passing scan follows pulse k, exactly k more margin pulses are applied and then a final scan runs, for 2k pulses in total.
- R9: If the scan still fails after MAX_PULSES pulses, `error` is raised and no further pulse is applied.
- R10: When the final scan passes, `eraseSel` and `latchEn` fall in the same cycle that `done` rises.
- R11: In the cycle `error` rises, `hvEn`, `eraseSel` and `latchEn` are all low.
- R12: If the final scan after the margin pulses finds a non-blank word, `error` is raised instead of `done`.
- R13: `done` and `error` hold until the next start, and an accepted start clears them on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, sampled in idle, done or error state |
| vfpOk | input | 1 | Programming supply present |
| rdData | input | DATA_W | Array read data, valid one cycle after `rdStrobe` |
| eraseSel | output | 1 | Erase mode select |
| latchEn | output | 1 | Array latch enable |
| wrStrobe | output | 1 | One-cycle arming write |
| hvEn | output | 1 | High-voltage pulse enable |
| rdStrobe | output | 1 | Read request |
| rdAddr | output | ADDR_W | Read word address, zero outside scans |
| done | output | 1 | Erase completed and verified |
| error | output | 1 | Erase aborted or failed |

## Verification
The bench builds the block with a 4-bit address, 8 user words, 4-cycle pulses, 3-cycle settling and the full budget of 5 pulses. The short pulse and settle windows make exact timing checks on every pulse cheap. The small user area, with programmed boot words placed above it, lets each scan's stopping address be predicted and shows that the boot region is skipped. A behavioural array that blanks after a chosen pulse, keeps one word stuck, or is re-programmed during the margin pulses drives the single-pulse, multi-pulse, exhausted-budget and failed-final-scan paths.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ARM, S_PULSE, S_SETTLE, S_CHKRD, S_CHKCMP, S_DONE, S_ERR
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;
    logic loadPulse;
    logic loadSettle;
    logic cntInc;
    logic cntDec;
    logic marginSet;
    logic addrClr;
    logic addrInc;
    logic rdStrobe;
  } seqCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic timerZero;
    logic cntIsOne;
    logic cntIsMax;
    logic marginOn;
    logic addrLast;
    logic wordBlank;
  } seqStat_t;

endpackage

// File: rtl/erase_seq_dp.sv
module erase_seq_dp
  import erase_seq_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int ADDR_W        = 14,
  parameter int CHECK_WORDS   = 15360,
  parameter int MAX_PULSES    = 5,
  parameter int PULSE_CYCLES  = 1250000,
  parameter int SETTLE_CYCLES = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqCmd_t           cmd,
  input  logic [DATA_W-1:0] rdData,
  output seqStat_t          st,
  output logic [ADDR_W-1:0] rdAddr
);

  localparam int MAX_DUR = (PULSE_CYCLES > SETTLE_CYCLES) ? PULSE_CYCLES : SETTLE_CYCLES;
  localparam int TIMER_W = $clog2(MAX_DUR + 1);
  localparam int CNT_W   = $clog2(MAX_PULSES + 1);
  localparam logic [TIMER_W-1:0] PULSE_LOAD  = TIMER_W'(PULSE_CYCLES - 1);
  localparam logic [TIMER_W-1:0] SETTLE_LOAD = TIMER_W'(SETTLE_CYCLES - 1);
  localparam logic [ADDR_W-1:0]  LAST_ADDR   = ADDR_W'(CHECK_WORDS - 1);

  logic [TIMER_W-1:0] timerQ;
  logic [CNT_W-1:0]   cntQ;
  logic               marginQ;
  logic [ADDR_W-1:0]  addrQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              timerQ <= '0;
    else if (cmd.loadPulse)  timerQ <= PULSE_LOAD;
    else if (cmd.loadSettle) timerQ <= SETTLE_LOAD;
    else if (timerQ != '0)   timerQ <= timerQ - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cntQ <= '0;
    else if (cmd.clrAll) cntQ <= '0;
    else if (cmd.cntInc) cntQ <= cntQ + 1'b1;
    else if (cmd.cntDec) cntQ <= cntQ - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             marginQ <= 1'b0;
    else if (cmd.clrAll)    marginQ <= 1'b0;
    else if (cmd.marginSet) marginQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           addrQ <= '0;
    else if (cmd.addrClr) addrQ <= '0;
    else if (cmd.addrInc) addrQ <= addrQ + 1'b1;
  end

  always_comb begin
    st.timerZero = (timerQ == '0);
    st.cntIsOne  = (cntQ == CNT_W'(1));
    st.cntIsMax  = (cntQ == CNT_W'(MAX_PULSES));
    st.marginOn  = marginQ;
    st.addrLast  = (addrQ == LAST_ADDR);
    st.wordBlank = (rdData == '1);
    rdAddr       = cmd.rdStrobe ? addrQ : '0;
  end

  // R9: pulse budget never exceeded
  a_r9_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cntQ <= CNT_W'(MAX_PULSES));

  // R7: reads stay inside the user area
  a_r7_read_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.rdStrobe |-> (32'(rdAddr) < CHECK_WORDS));

endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import erase_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     vfpOk,
  input  seqStat_t st,
  output seqCmd_t  cmd,
  output logic     eraseSel,
  output logic     latchEn,
  output logic     wrStrobe,
  output logic     hvEn,
  output logic     done,
  output logic     error
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    unique case (state)
      S_IDLE, S_DONE, S_ERR: begin
        if (start) begin
          cmd.clrAll = 1'b1;
          nextState  = vfpOk ? S_ARM : S_ERR;
        end
      end
      S_ARM: begin
        cmd.loadPulse = 1'b1;
        cmd.cntInc    = 1'b1;
        nextState     = S_PULSE;
      end
      S_PULSE: begin
        if (st.timerZero) begin
          cmd.loadSettle = 1'b1;
          nextState      = S_SETTLE;
        end
      end
      S_SETTLE: begin
        if (st.timerZero) begin
          if (st.marginOn) begin
            cmd.cntDec = 1'b1;
            if (st.cntIsOne) begin
              cmd.addrClr = 1'b1;
              nextState   = S_CHKRD;
            end else begin
              cmd.loadPulse = 1'b1;
              nextState     = S_PULSE;
            end
          end else begin
            cmd.addrClr = 1'b1;
            nextState   = S_CHKRD;
          end
        end
      end
      S_CHKRD: begin
        cmd.rdStrobe = 1'b1;
        nextState    = S_CHKCMP;
      end
      S_CHKCMP: begin
        if (!st.wordBlank) begin
          if (st.marginOn || st.cntIsMax) begin
            nextState = S_ERR;
          end else begin
            cmd.loadPulse = 1'b1;
            cmd.cntInc    = 1'b1;
            nextState     = S_PULSE;
          end
        end else if (st.addrLast) begin
          if (st.marginOn) begin
            nextState = S_DONE;
          end else begin
            cmd.marginSet = 1'b1;
            cmd.loadPulse = 1'b1;
            nextState     = S_PULSE;
          end
        end else begin
          cmd.addrInc = 1'b1;
          nextState   = S_CHKRD;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_comb begin
    eraseSel = (state == S_ARM) || (state == S_PULSE) || (state == S_SETTLE) ||
               (state == S_CHKRD) || (state == S_CHKCMP);
    latchEn  = eraseSel;
    wrStrobe = (state == S_ARM);
    hvEn     = (state == S_PULSE);
    done     = (state == S_DONE);
    error    = (state == S_ERR);
  end

  // R4: high voltage only while the array is armed for erase
  a_r4_hv_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    hvEn |-> (eraseSel && latchEn));

  // R2: missing supply at start aborts at once
  a_r2_no_supply_abort: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_IDLE) && start && !vfpOk) |=> error);

  // R3: the arming write is followed directly by the first pulse
  a_r3_write_then_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wrStrobe |=> hvEn);

  // R11: an error never coincides with an active pulse
  a_r11_error_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> $past(!hvEn));

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import erase_seq_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int ADDR_W        = 14,
  parameter int CHECK_WORDS   = 15360,
  parameter int MAX_PULSES    = 5,
  parameter int PULSE_CYCLES  = 1250000,
  parameter int SETTLE_CYCLES = 1250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              vfpOk,
  input  logic [DATA_W-1:0] rdData,
  output logic              eraseSel,
  output logic              latchEn,
  output logic              wrStrobe,
  output logic              hvEn,
  output logic              rdStrobe,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              done,
  output logic              error
);

  seqCmd_t  cmd;
  seqStat_t st;

  erase_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vfpOk(vfpOk), .st(st), .cmd(cmd),
    .eraseSel(eraseSel), .latchEn(latchEn), .wrStrobe(wrStrobe), .hvEn(hvEn),
    .done(done), .error(error)
  );

  erase_seq_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHECK_WORDS(CHECK_WORDS),
    .MAX_PULSES(MAX_PULSES), .PULSE_CYCLES(PULSE_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .rdData(rdData), .st(st), .rdAddr(rdAddr)
  );

  assign rdStrobe = cmd.rdStrobe;

endmodule

// File: tb/flash_erase_seq_bench.sv
module flash_erase_seq_bench;

  localparam int DW = 16, AW = 4, CW = 8, MAXP = 5, PC = 4, SC = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, vfpOk = 1'b1;
  logic [DW-1:0] rdData = '0;
  logic eraseSel, latchEn, wrStrobe, hvEn, rdStrobe, done, error;
  logic [AW-1:0] rdAddr;

  flash_erase_seq #(.DATA_W(DW), .ADDR_W(AW), .CHECK_WORDS(CW), .MAX_PULSES(MAXP),
                    .PULSE_CYCLES(PC), .SETTLE_CYCLES(SC)) u_flash_erase_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vfpOk(vfpOk), .rdData(rdData),
    .eraseSel(eraseSel), .latchEn(latchEn), .wrStrobe(wrStrobe), .hvEn(hvEn),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr), .done(done), .error(error));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [DW-1:0] mem [16];
  int eraseAfter = 99, stuckIdx = -1, corruptAt = 99;
  int pulses = 0, hvLen = 0, gapCnt = 0, expAddr = 0, wrCnt = 0, bootReads = 0;
  int badLen = 0, badGap = 0, badOrder = 0, badArm = 0, badPair = 0;
  int scanEnd [16];
  bit prevHv = 0, inGap = 0, lastEs = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // synchronous-read array model: data one cycle after the strobe
  always @(posedge clk) if (rdStrobe) rdData <= mem[rdAddr];

  // negedge monitor and erase behaviour of the array
  always @(negedge clk) begin
    if (hvEn) begin
      if (inGap) begin if (gapCnt != SC) badGap++; inGap = 0; end
      if (!prevHv) expAddr = 0;
      hvLen++;
    end else if (prevHv) begin
      pulses++;
      if (hvLen != PC) badLen++;
      hvLen = 0; inGap = 1; gapCnt = 1;
      if (pulses == eraseAfter)
        for (int i = 0; i < CW; i++) if (i != stuckIdx) mem[i] = '1;
      if (pulses == eraseAfter + 1 && stuckIdx >= 0) mem[stuckIdx] = '1;
      if (pulses == corruptAt) mem[3] = 16'h0000;
    end else if (inGap) begin
      if (rdStrobe) begin if (gapCnt != SC) badGap++; inGap = 0; end
      else gapCnt++;
    end
    if (rdStrobe) begin
      if (int'(rdAddr) != expAddr) badOrder++;
      if (int'(rdAddr) >= CW) bootReads++;
      scanEnd[pulses] = int'(rdAddr);
      expAddr++;
    end
    if (wrStrobe) begin
      wrCnt++;
      if (!(eraseSel && latchEn) || pulses != 0 || hvEn) badArm++;
    end
    if (eraseSel != latchEn) badPair++;
    prevHv = hvEn;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic prepArray(input int ea, input int stk, input int cor);
    eraseAfter = ea; stuckIdx = stk; corruptAt = cor;
    for (int i = 0; i < 16; i++) mem[i] = 16'h1000 + 16'(i);
    for (int i = 0; i < 16; i++) scanEnd[i] = -1;
    pulses = 0; hvLen = 0; gapCnt = 0; inGap = 0; expAddr = 0; wrCnt = 0;
    bootReads = 0; badLen = 0; badGap = 0; badOrder = 0; badArm = 0; badPair = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitEnd();
    lastEs = eraseSel && latchEn;
    for (int n = 0; n < 5000; n++) begin
      if (done || error) break;
      lastEs = eraseSel && latchEn;
      @(negedge clk);
    end
  endtask

  task automatic checkTiming(input string tag);
    check(badLen == 0, "R4", {tag, " pulse length errors"}, badLen, 0);
    check(badGap == 0, "R4", {tag, " settle gap errors"}, badGap, 0);
    check(badOrder == 0, "R5", {tag, " read order errors"}, badOrder, 0);
    check(bootReads == 0, "R7", {tag, " boot region reads"}, bootReads, 0);
    check(badPair == 0, "R3", {tag, " select/latch split"}, badPair, 0);
  endtask

  task automatic testReset();
    #1;
    check(!eraseSel && !latchEn && !wrStrobe && !hvEn && !rdStrobe && !done && !error,
          "R1", "outputs in reset", {eraseSel, latchEn, wrStrobe, hvEn, rdStrobe, done, error}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!eraseSel && !hvEn && !done && !error && rdAddr == '0, "R1", "outputs idle",
          {eraseSel, hvEn, done, error}, 0);
  endtask

  task automatic testNoSupply();
    prepArray(1, -1, 99);
    vfpOk = 1'b0;
    pulseStart();
    check(error == 1'b1, "R2", "error after start without supply", error, 1);
    check(wrCnt == 0 && !hvEn, "R2", "write strobes issued", wrCnt, 0);
    check(!eraseSel && !latchEn, "R11", "select/latch at abort", eraseSel, 0);
    vfpOk = 1'b1;
  endtask

  task automatic testOnePulse();
    prepArray(1, -1, 99);
    pulseStart();
    check(done == 1'b0 && error == 1'b0, "R13", "flags cleared by start", {done, error}, 0);
    check(eraseSel && latchEn && wrStrobe, "R3", "arm cycle", {eraseSel, latchEn, wrStrobe}, 7);
    waitEnd();
    check(done == 1'b1, "R8", "done after one blanking pulse", done, 1);
    check(pulses == 2, "R8", "total pulses k=1", pulses, 2);
    check(wrCnt == 1 && badArm == 0, "R3", "single arming write", wrCnt, 1);
    check(!eraseSel && !latchEn && lastEs, "R10", "select/latch drop with done",
          {lastEs, eraseSel, latchEn}, 4);
    checkTiming("k=1");
    repeat (10) @(negedge clk);
    check(done == 1'b1 && error == 1'b0, "R13", "done held", done, 1);
  endtask

  task automatic testThreePulses();
    prepArray(3, -1, 99);
    pulseStart();
    waitEnd();
    check(done == 1'b1, "R8", "done after three pulses", done, 1);
    check(pulses == 6, "R8", "total pulses k=3", pulses, 6);
    check(scanEnd[1] == 0 && scanEnd[2] == 0, "R6", "early scans stop at word 0",
          scanEnd[1] + scanEnd[2], 0);
    check(scanEnd[3] == CW - 1, "R7", "passing scan ends at last user word", scanEnd[3], CW - 1);
    checkTiming("k=3");
  endtask

  task automatic testStuckWord();
    prepArray(1, 5, 99);
    pulseStart();
    waitEnd();
    check(scanEnd[1] == 5, "R6", "scan stops at stuck word", scanEnd[1], 5);
    check(pulses == 4 && done, "R8", "total pulses with one stuck retry", pulses, 4);
    check(scanEnd[4] == CW - 1, "R5", "final scan covers user area", scanEnd[4], CW - 1);
    checkTiming("stuck");
  endtask

  task automatic testNeverBlank();
    prepArray(99, -1, 99);
    pulseStart();
    waitEnd();
    check(error == 1'b1 && done == 1'b0, "R9", "error after budget", error, 1);
    repeat (20) @(negedge clk);
    check(pulses == MAXP, "R9", "pulses applied", pulses, MAXP);
    check(!hvEn && !eraseSel && !latchEn, "R11", "quiet outputs at error",
          {hvEn, eraseSel, latchEn}, 0);
    checkTiming("never");
  endtask

  task automatic testFinalFail();
    prepArray(2, -1, 3);
    pulseStart();
    waitEnd();
    check(error == 1'b1 && done == 1'b0, "R12", "error on failed final scan", error, 1);
    check(pulses == 4, "R12", "pulses before final scan", pulses, 4);
    check(scanEnd[4] == 3, "R12", "final scan stops at corrupted word", scanEnd[4], 3);
    check(!eraseSel && !latchEn && lastEs, "R11", "select/latch drop with error",
          {lastEs, eraseSel, latchEn}, 4);
  endtask

  initial begin
    prepArray(99, -1, 99);
    testReset();
    testNoSupply();
    testOnePulse();
    testThreePulses();
    testStuckWord();
    testNeverBlank();
    testFinalFail();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule